// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

The block holds six independent down-counters, each programmed through a small memory-mapped register set inside a 1 KB window. A channel advances only on pulses from one of four clock-enable inputs, selected in its control register, after those pulses pass a power-of-two prescaler. A channel is set up with a start value and a mode. When the count runs out, the channel raises its status bit. A periodic channel then restarts from its interval. A one-shot channel parks at zero and turns itself off.

A shared enable register masks the six status bits onto six interrupt lines. Software acknowledges an interrupt by writing a one to its status bit. Two further words are plain storage for a companion watchdog and have no effect on the counters. Register reads are combinational. A write takes effect at the next clock edge.

Top module: `interval_timer_bank`

## Requirements
- R1: Address decode: offset 0x000 is the interrupt-enable register and 0x004 the interrupt-status register (bit k belongs to channel k). Channel k (0..5) sits at base 0x10*(k+1), so bits [7:4] of the offset minus one give the channel, and bits [3:0] select the register: 0x0 control, 0x4 interval, 0x8 count.
- R2: Control layout: bit 0 is enable, bit 1 is reload (acted on at the write and always reads 0), bits [3:2] pick source input src_tick[n], bits [6:4] hold the prescaler exponent e, and bit 7 selects one-shot (1) or periodic (0).
- R3: While enabled, a channel takes one count step per 2^e pulses of its selected source. The prescaler restarts on every control write.
- R4: Writing interval sets both the reload value and the counter. Writing count sets only the counter.
- R5: A control write with the reload bit set copies the interval into the counter.
- R6: A step taken with the counter at 1 or 0 is an expiry and sets the channel's status bit. Periodic mode then reloads the interval. One-shot mode sets the counter to 0 and clears the enable bit. Any other step decrements the counter.
- R7: Writing the status register clears each bit written as 1 and leaves the others.
- R8: irq[k] is high exactly when status bit k and enable bit k are both 1.
- R9: Reset clears all enables, status, control, interval and count registers.
- R10: A channel with enable 0 holds its counter. A channel whose selected source input stays low never changes its counter.
- R11: Offsets 0x090 and 0x094 store a full 32-bit word that reads back unchanged. Every other offset, including channel slots 7..15 and unused channel sub-offsets, reads 0.
- R12: An expiry in the same cycle as a status write that clears that bit leaves the bit set. A write to a channel's control, interval or count register in a cycle drops that channel's step for the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 10 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_tick | input | 4 | Clock-enable pulses of the four sources |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
An expiry can land in the same cycle as a software write to the status register, or in the same cycle as a write to that channel's own registers. The bench forces the first case with a channel at interval 1 and its source pulsing every cycle, then writes a clear. The status bit must stay set. With the pulses stopped, a second clear must succeed. The random phase mixes register writes with source pulses on every cycle. Each clash is therefore judged against the bench model's rule that set wins on status, and that a register write suppresses the step.

// File: rtl/interval_timer_bank.sv
module interval_timer_bank #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    src_tick,
  output logic [NCH-1:0] irq
);
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_IEN = AW'(12'h000);
  localparam logic [AW-1:0] A_IST = AW'(12'h004);
  localparam logic [AW-1:0] A_WDC = AW'(12'h090);
  localparam logic [AW-1:0] A_WDM = AW'(12'h094);

  logic [NCH-1:0]          ien, ist, expire, chw, step;
  logic [NCH-1:0][7:0]     ctl;
  logic [NCH-1:0][DW-1:0]  intv, cnt;
  logic [NCH-1:0][6:0]     pre;
  logic [DW-1:0]           wdc, wdm;

  wire         wr    = bus_sel & bus_we;
  wire [3:0]   hi    = bus_addr[7:4];
  wire [3:0]   lo    = bus_addr[3:0];
  wire         in_ch = (bus_addr[AW-1:8] == '0) && (hi != 4'd0) && (int'(hi) <= NCH);
  wire [3:0]   ch    = hi - 4'd1;
  wire [CIW-1:0] chi = ch[CIW-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire hit   = wr && in_ch && (ch == 4'(i));
    wire w_ctl = hit && (lo == 4'h0);
    wire w_int = hit && (lo == 4'h4);
    wire w_cnt = hit && (lo == 4'h8);
    wire tk    = src_tick[ctl[i][3:2]];
    wire [6:0] msk = 7'((8'd1 << ctl[i][6:4]) - 8'd1);
    wire run   = ctl[i][0] && tk && !chw[i];

    assign chw[i]    = w_ctl | w_int | w_cnt;
    assign step[i]   = run && ((pre[i] & msk) == msk);
    assign expire[i] = step[i] && (cnt[i] <= DW'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl[i]  <= '0;
        intv[i] <= '0;
        cnt[i]  <= '0;
        pre[i]  <= '0;
      end else if (w_ctl) begin
        ctl[i] <= {bus_wdata[7:2], 1'b0, bus_wdata[0]};
        pre[i] <= '0;
        if (bus_wdata[1]) cnt[i] <= intv[i];
      end else if (w_int) begin
        intv[i] <= bus_wdata;
        cnt[i]  <= bus_wdata;
      end else if (w_cnt) begin
        cnt[i] <= bus_wdata;
      end else if (run) begin
        pre[i] <= step[i] ? 7'd0 : pre[i] + 7'd1;
        if (expire[i]) begin
          if (ctl[i][7]) begin
            cnt[i]    <= '0;
            ctl[i][0] <= 1'b0;
          end else begin
            cnt[i] <= intv[i];
          end
        end else if (step[i]) begin
          cnt[i] <= cnt[i] - DW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien <= '0;
      ist <= '0;
      wdc <= '0;
      wdm <= '0;
    end else begin
      if (wr && bus_addr == A_IEN) ien <= bus_wdata[NCH-1:0];
      if (wr && bus_addr == A_IST) ist <= (ist & ~bus_wdata[NCH-1:0]) | expire;
      else                         ist <= ist | expire;
      if (wr && bus_addr == A_WDC) wdc <= bus_wdata;
      if (wr && bus_addr == A_WDM) wdm <= bus_wdata;
    end
  end

  assign irq = ist & ien;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_IEN)      bus_rdata = DW'(ien);
    else if (bus_addr == A_IST) bus_rdata = DW'(ist);
    else if (bus_addr == A_WDC) bus_rdata = wdc;
    else if (bus_addr == A_WDM) bus_rdata = wdm;
    else if (in_ch) begin
      case (lo)
        4'h0:    bus_rdata = DW'(ctl[chi]);
        4'h4:    bus_rdata = intv[chi];
        4'h8:    bus_rdata = cnt[chi];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/interval_timer_bank_props.sv
module interval_timer_bank_props #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_we,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_wdata,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         ist,
  input logic [NCH-1:0]         ien,
  input logic [NCH-1:0]         expire,
  input logic [NCH-1:0]         chw,
  input logic [NCH-1:0]         step,
  input logic [NCH-1:0][7:0]    ctl,
  input logic [NCH-1:0][DW-1:0] cnt
);
  wire st_wr = bus_sel && bus_we && (bus_addr == AW'(12'h004));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ist == '0 && ien == '0));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((ist & $past(bus_wdata[NCH-1:0]) & ~$past(expire)) == '0));

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != '0) |=> ((ist & $past(expire)) == $past(expire)));

  p_status_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ist & ~$past(ist) & ~$past(expire)) == '0));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~ist) == '0) && ((irq & ~ien) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    p_oneshot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && ctl[i][7]) |=> !ctl[i][0]);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!step[i] && !chw[i]) |=> $stable(cnt[i]));
    p_suppress_r12: assert property (@(posedge clk) disable iff (!rst_n)
      chw[i] |-> !step[i]);
  end
endmodule

bind interval_timer_bank interval_timer_bank_props #(.NCH(NCH), .DW(DW), .AW(AW)) u_props (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .ist(ist), .ien(ien), .expire(expire), .chw(chw),
  .step(step), .ctl(ctl), .cnt(cnt)
);

// File: tb/sim_interval_timer_bank.sv
module sim_interval_timer_bank;
  localparam int TCLK = 10;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] src_tick = '0;
  logic [5:0] irq;
  int nvec = 0, nbad = 0;

  interval_timer_bank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .irq(irq));

  always #(TCLK/2) clk = ~clk;

  logic [7:0]  m_ctl [6];
  logic [31:0] m_int [6], m_cnt [6];
  int          m_pre [6];
  logic [5:0]  m_ien, m_ist;
  logic [31:0] m_wdc, m_wdm;
  logic [7:0]  n_ctl [6];
  logic [31:0] n_int [6], n_cnt [6];
  int          n_pre [6];
  logic [5:0]  n_ien, n_ist;
  logic [31:0] n_wdc, n_wdm;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [9:0] a);
    int h = int'(a[7:4]);
    if (a == 10'h000) return {26'd0, m_ien};
    if (a == 10'h004) return {26'd0, m_ist};
    if (a == 10'h090) return m_wdc;
    if (a == 10'h094) return m_wdm;
    if (a[9:8] == 2'b00 && h >= 1 && h <= 6) begin
      if (a[3:0] == 4'h0) return {24'd0, m_ctl[h-1]};
      if (a[3:0] == 4'h4) return m_int[h-1];
      if (a[3:0] == 4'h8) return m_cnt[h-1];
    end
    return 32'd0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 6; i++) begin
      m_ctl[i] = 0; m_int[i] = 0; m_cnt[i] = 0; m_pre[i] = 0;
    end
    m_ien = 0; m_ist = 0; m_wdc = 0; m_wdm = 0;
  endtask

  task automatic cyc(input logic we, input logic [9:0] a, input logic [31:0] d, input logic [3:0] t);
    logic [5:0] clr = 0, setb = 0;
    int h = int'(a[7:4]);
    bit inch = (a[9:8] == 2'b00) && h >= 1 && h <= 6;
    bus_sel = we; bus_we = we; bus_addr = a; bus_wdata = d; src_tick = t;
    n_ien = m_ien; n_wdc = m_wdc; n_wdm = m_wdm;
    if (we && a == 10'h000) n_ien = d[5:0];
    if (we && a == 10'h004) clr = d[5:0];
    if (we && a == 10'h090) n_wdc = d;
    if (we && a == 10'h094) n_wdm = d;
    for (int i = 0; i < 6; i++) begin
      bit hit = we && inch && (h == i + 1) &&
                (a[3:0] == 4'h0 || a[3:0] == 4'h4 || a[3:0] == 4'h8);
      n_ctl[i] = m_ctl[i]; n_int[i] = m_int[i]; n_cnt[i] = m_cnt[i]; n_pre[i] = m_pre[i];
      if (hit) begin
        if (a[3:0] == 4'h0) begin
          n_ctl[i] = {d[7:2], 1'b0, d[0]}; n_pre[i] = 0;
          if (d[1]) n_cnt[i] = m_int[i];
        end else if (a[3:0] == 4'h4) begin
          n_int[i] = d; n_cnt[i] = d;
        end else n_cnt[i] = d;
      end else if (m_ctl[i][0] && t[m_ctl[i][3:2]]) begin
        if (m_pre[i] + 1 == (1 << m_ctl[i][6:4])) begin
          n_pre[i] = 0;
          if (m_cnt[i] <= 1) begin
            setb[i] = 1'b1;
            if (m_ctl[i][7]) begin n_cnt[i] = 0; n_ctl[i][0] = 1'b0; end
            else n_cnt[i] = m_int[i];
          end else n_cnt[i] = m_cnt[i] - 1;
        end else n_pre[i] = m_pre[i] + 1;
      end
    end
    n_ist = (m_ist & ~clr) | setb;
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) begin
      m_ctl[i] = n_ctl[i]; m_int[i] = n_int[i]; m_cnt[i] = n_cnt[i]; m_pre[i] = n_pre[i];
    end
    m_ien = n_ien; m_ist = n_ist; m_wdc = n_wdc; m_wdm = n_wdm;
    bus_sel = 0; bus_we = 0; src_tick = 0;
    chk("R8 irq", {26'd0, irq}, {26'd0, m_ist & m_ien});
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 4'd0);
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [31:0] exp);
    bus_sel = 1; bus_we = 0; bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic rd_all(input string req);
    rd(req, 10'h000, m_read(10'h000));
    rd(req, 10'h004, m_read(10'h004));
    for (int i = 1; i <= 6; i++) begin
      rd(req, 10'(i*16),     m_read(10'(i*16)));
      rd(req, 10'(i*16 + 4), m_read(10'(i*16 + 4)));
      rd(req, 10'(i*16 + 8), m_read(10'(i*16 + 8)));
    end
  endtask

  initial begin
    #(TCLK*150000);
    nbad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int seed;
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    for (int i = 1; i <= 6; i++) begin
      rd("R9 ctl", 10'(i*16), 32'd0);
      rd("R9 int", 10'(i*16+4), 32'd0);
      rd("R9 cnt", 10'(i*16+8), 32'd0);
    end
    rd("R9 ien", 10'h000, 0); rd("R9 ist", 10'h004, 0);
    chk("R9 irq", {26'd0, irq}, 0);

    // R3 R4: ch0 interval 3, source 1, exponent 2 -> expiry on 12th pulse
    wr(10'h000, 32'h3F);
    wr(10'h014, 32'd3);
    rd("R4 interval loads count", 10'h018, 32'd3);
    wr(10'h010, 32'h25);
    for (int k = 1; k <= 11; k++) cyc(0, 10'h0, 0, 4'b0010);
    chk("R3 no expiry before 12 pulses", {31'd0, irq[0]}, 0);
    rd("R3 count after 11", 10'h018, 32'd1);
    cyc(0, 10'h0, 0, 4'b0010);
    chk("R3 expiry on 12th pulse", {31'd0, irq[0]}, 1);
    rd("R6 periodic reload", 10'h018, 32'd3);
    wr(10'h004, 32'h01);
    chk("R7 clear by one", {31'd0, irq[0]}, 0);
    wr(10'h010, 32'h00);

    // R6 one-shot on ch1
    wr(10'h024, 32'd2);
    wr(10'h020, 32'h81);
    cyc(0, 0, 0, 4'b0001); cyc(0, 0, 0, 4'b0001);
    rd("R6 one-shot clears enable", 10'h020, 32'h80);
    rd("R6 one-shot parks at zero", 10'h028, 32'd0);
    chk("R6 status set", {31'd0, irq[1]}, 1);
    repeat (5) cyc(0, 0, 0, 4'b0001);
    rd("R10 stopped after one-shot", 10'h028, 32'd0);
    wr(10'h004, 32'h02);
    rd("R7 status clear", 10'h004, 32'd0);

    // R12 set wins over clear
    wr(10'h034, 32'd1);
    wr(10'h030, 32'h01);
    cyc(0, 0, 0, 4'b0001);
    rd("R12 expired", 10'h004, 32'h04);
    cyc(1, 10'h004, 32'h04, 4'b0001);
    rd("R12 set wins", 10'h004, 32'h04);
    wr(10'h030, 32'h00);
    wr(10'h004, 32'h04);
    rd("R7 clear without expiry", 10'h004, 32'h00);
    // R12 write suppresses step
    wr(10'h034, 32'd5);
    wr(10'h030, 32'h01);
    cyc(1, 10'h038, 32'd4, 4'b0001);
    rd("R12 write wins over step", 10'h038, 32'd4);
    wr(10'h030, 32'h00);

    // R10 tied source and disabled channel
    wr(10'h044, 32'd7);
    wr(10'h040, 32'h0D);
    repeat (20) cyc(0, 0, 0, 4'b0111);
    rd("R10 idle source holds", 10'h048, 32'd7);
    wr(10'h040, 32'h00);
    repeat (5) cyc(0, 0, 0, 4'b1111);
    rd("R10 disabled holds", 10'h048, 32'd7);

    // R5 reload bit, R2 readback
    wr(10'h054, 32'd9);
    wr(10'h058, 32'd2);
    wr(10'h050, 32'h02);
    rd("R5 reload copies interval", 10'h058, 32'd9);
    rd("R2 reload reads zero", 10'h050, 32'd0);

    // R11 storage and unmapped
    wr(10'h090, 32'hDEADBEEF);
    wr(10'h094, 32'h12345678);
    rd("R11 store a", 10'h090, 32'hDEADBEEF);
    rd("R11 store b", 10'h094, 32'h12345678);
    rd("R11 unmapped slot", 10'h070, 0);
    rd("R11 unmapped high", 10'h200, 0);
    rd("R11 unmapped sub", 10'h01C, 0);
    wr(10'h070, 32'hFFFFFFFF);
    rd("R1 slot 7 write ignored", 10'h070, 0);
    rd_all("R1 map after directed");

    // random phase
    seed = $urandom(1234);
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      logic [3:0] t = 4'($urandom_range(0, 7));
      if (r < 12) begin
        int c = $urandom_range(1, 6);
        int s = $urandom_range(0, 2);
        logic [31:0] d;
        if (s == 0) d = {24'd0, 1'($urandom_range(0,1)), 3'($urandom_range(0,2)),
                         2'($urandom_range(0,3)), 1'($urandom_range(0,1)), 1'b1};
        else d = 32'($urandom_range(0, 12));
        cyc(1, 10'(c*16 + s*4), d, t);
      end else if (r < 15) cyc(1, 10'h004, 32'($urandom_range(0, 63)), t);
      else if (r < 17) cyc(1, 10'h000, 32'($urandom_range(0, 63)), t);
      else cyc(0, 0, 0, t);
      if (n % 200 == 199) rd_all("R1 R6 random");
    end
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    m_reset();
    rd_all("R9 reset after run");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule